// File: doc/BRIEF.md
# CAN Card Host Bus Glue with Interrupt Gate

This block is the host-facing glue for an add-in card that carries one byte-wide CAN controller. The host sees three I/O windows, each with its own select line. They share one address bus, one write-data bus and one write strobe. The first window is a 128-byte bridge window. It holds a single 32-bit interrupt control/status word. The second window is a 128-byte controller window. It forwards byte accesses into the controller's 32-byte register file and returns zero above that range. The third window is an 8-byte auxiliary window. It holds a read-only version byte.

The controller's level interrupt is recorded on every clock. It reaches the host interrupt output only while the add-on enable bit of the control/status word is set. The raw level can always be read in a status bit, whatever the state of the enable bit. Read data is returned combinationally in the same cycle as the select. Writes take effect at the next rising clock edge. The host interrupt output is a register, so it moves on the edge after the write or the level change that caused it. Only one select is expected to be high in any cycle.

Top module: `canbridge_glue`

## Requirements
- R1: While reset is asserted and after it is released, the control/status word reads as zero and the host interrupt output is low.
- R2: A write to bridge offset 0x38 stores all 32 bits. A read of that offset returns the stored word, except that bit 23 is replaced as described in R3.
- R3: Bit 23 of a control/status read shows the controller interrupt level sampled at the previous clock edge, whatever value was written to that bit.
- R4: While bit 13 (mask 0x0000_2000) is set, the host interrupt output follows the controller interrupt level one clock edge after the level changes.
- R5: When bit 13 is written to a new value while the controller interrupt is pending, the host interrupt output takes the new bit 13 value on the edge that commits the write.
- R6: While bit 13 is clear, changes of the controller interrupt level leave the host interrupt output low.
- R7: Bridge offsets other than 0x38 read as zero. Writes to them change neither the control/status word nor the host interrupt output.
- R8: A controller-window access at an offset below 0x20 raises the controller read strobe or write strobe in the same cycle. It presents the low five address bits and the low data byte, and it returns the controller's read byte in bits 7:0 of the read data with the upper bits zero.
- R9: A controller-window access at offset 0x20 or above raises no controller strobe, and a read there returns zero.
- R10: Auxiliary offset 7 reads as 0xD0 (version 13 in bits 7:4, zero in bits 3:0). Every other auxiliary offset reads as zero, and writes to the auxiliary window change nothing.
- R11: The controller reset request is high throughout reset and for the first clock cycle after release, then goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_sel | input | 1 | Selects the bridge window |
| ctrl_sel | input | 1 | Selects the controller window |
| aux_sel | input | 1 | Selects the auxiliary window |
| addr | input | 7 | Byte offset within the selected window |
| wdata | input | 32 | Write data |
| wr | input | 1 | High for a write, low for a read |
| rdata | output | 32 | Read data for the selected window |
| ctl_rd | output | 1 | Read strobe to the controller |
| ctl_wr | output | 1 | Write strobe to the controller |
| ctl_addr | output | 5 | Controller register offset |
| ctl_wdata | output | 8 | Byte written to the controller |
| ctl_rdata | input | 8 | Byte read from the controller |
| ctl_irq | input | 1 | Controller interrupt level |
| ctl_rst | output | 1 | Reset request to the controller |
| host_irq | output | 1 | Gated host interrupt line |

## Verification
The hardest case to reach from the ports is a change of the enable bit while an interrupt is already pending. The controller level must first be raised with the enable clear, and bit 23 must show it while the host line stays low. Only then does a write set the enable bit, and a later write clear it. The host line has to move at each of those writes without any change in the level. The same pending state is used to show that a write carrying bit 13 to another bridge offset has no effect on the host line.

// File: rtl/canbridge_glue.sv
module canbridge_glue #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int BYTE_W   = 8,
  parameter int CTL_SPAN = 32,
  parameter int CSR_OFS  = 'h38,
  parameter int EN_BIT   = 13,
  parameter int PEND_BIT = 23,
  parameter int VER_OFS  = 7,
  parameter int VER_NUM  = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bridge_sel,
  input  logic                          ctrl_sel,
  input  logic                          aux_sel,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          wr,
  output logic [DATA_W-1:0]             rdata,
  output logic                          ctl_rd,
  output logic                          ctl_wr,
  output logic [$clog2(CTL_SPAN)-1:0]   ctl_addr,
  output logic [BYTE_W-1:0]             ctl_wdata,
  input  logic [BYTE_W-1:0]             ctl_rdata,
  input  logic                          ctl_irq,
  output logic                          ctl_rst,
  output logic                          host_irq
);
  localparam int CTL_AW = $clog2(CTL_SPAN);
  localparam logic [ADDR_W-1:0] CSR_A  = ADDR_W'(CSR_OFS);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(CTL_SPAN);
  localparam logic [ADDR_W-1:0] VER_A  = ADDR_W'(VER_OFS);
  localparam logic [BYTE_W-1:0] VER_BYTE = BYTE_W'(VER_NUM << 4);

  logic [DATA_W-1:0] csr_q;
  logic              raw_q;
  logic              host_q;
  logic              rst_pend_q;

  wire csr_hit = bridge_sel && (addr == CSR_A);
  wire csr_wr  = csr_hit && wr;
  wire ctl_hit = ctrl_sel && (addr < SPAN_A);
  wire ver_hit = aux_sel && (addr == VER_A);

  wire en_now  = csr_q[EN_BIT];
  wire en_new  = csr_wr ? wdata[EN_BIT] : en_now;
  wire irq_chg = ctl_irq ^ raw_q;
  wire en_flip = csr_wr && (wdata[EN_BIT] ^ en_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q      <= '0;
      raw_q      <= 1'b0;
      host_q     <= 1'b0;
      rst_pend_q <= 1'b1;
    end else begin
      rst_pend_q <= 1'b0;
      raw_q      <= ctl_irq;
      if (csr_wr) csr_q <= wdata;
      if (irq_chg && en_new)
        host_q <= ctl_irq;
      else if (en_flip && raw_q)
        host_q <= wdata[EN_BIT];
    end
  end

  logic [DATA_W-1:0] status;
  always_comb begin
    status = csr_q;
    status[PEND_BIT] = raw_q;
  end

  always_comb begin
    rdata = '0;
    if (csr_hit)      rdata = status;
    else if (ctl_hit) rdata = DATA_W'(ctl_rdata);
    else if (ver_hit) rdata = DATA_W'(VER_BYTE);
  end

  assign ctl_rd    = ctl_hit && !wr;
  assign ctl_wr    = ctl_hit && wr;
  assign ctl_addr  = addr[CTL_AW-1:0];
  assign ctl_wdata = wdata[BYTE_W-1:0];
  assign ctl_rst   = rst_pend_q;
  assign host_irq  = host_q;

  // R4/R5/R6: the event-driven host line must always equal enable AND recorded level
  a_r4_host_gated: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == (csr_q[EN_BIT] & raw_q));

  a_r7_other_ofs_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_sel && wr && addr != CSR_A) |=> $stable(csr_q));

  a_r9_strobe_in_span: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd || ctl_wr) |-> (ctrl_sel && addr < SPAN_A));

  a_r10_aux_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_sel && addr != VER_A && !bridge_sel && !ctrl_sel) |-> rdata == '0);

  a_r11_rst_once: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |=> !ctl_rst);

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_rd, ctl_wr}));
endmodule

// File: tb/canbridge_glue_test.sv
module canbridge_glue_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bridge_sel = 0, ctrl_sel = 0, aux_sel = 0, wr = 0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ctl_rd, ctl_wr, ctl_rst, host_irq;
  logic [4:0]  ctl_addr;
  logic [7:0]  ctl_wdata, ctl_rdata;
  logic        ctl_irq = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;

  logic [31:0] cap_rdata;
  logic        cap_rd, cap_wr;
  logic [4:0]  cap_addr;
  logic [7:0]  cap_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ctl_rdata = 8'hA0 | {3'b000, ctl_addr};

  canbridge_glue uut (
    .clk(clk), .rst_n(rst_n), .bridge_sel(bridge_sel), .ctrl_sel(ctrl_sel),
    .aux_sel(aux_sel), .addr(addr), .wdata(wdata), .wr(wr), .rdata(rdata),
    .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .ctl_irq(ctl_irq), .ctl_rst(ctl_rst), .host_irq(host_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // win: 0 bridge, 1 controller, 2 aux. Called just after a falling edge.
  task automatic access(int win, logic [6:0] a, logic w, logic [31:0] d);
    bridge_sel = (win == 0);
    ctrl_sel   = (win == 1);
    aux_sel    = (win == 2);
    addr = a; wr = w; wdata = d;
    #1;
    cap_rdata = rdata; cap_rd = ctl_rd; cap_wr = ctl_wr;
    cap_addr = ctl_addr; cap_wdata = ctl_wdata;
    @(posedge clk);
    @(negedge clk);
    bridge_sel = 0; ctrl_sel = 0; aux_sel = 0; wr = 0;
    #1;
  endtask

  task automatic idle_cycle();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    check("R1 host low in reset", {31'b0, host_irq}, 32'd0);
    check("R11 ctl_rst in reset", {31'b0, ctl_rst}, 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R11 ctl_rst first cycle", {31'b0, ctl_rst}, 32'd1);
    idle_cycle();
    check("R11 ctl_rst released", {31'b0, ctl_rst}, 32'd0);
    access(0, 7'h38, 0, 0);
    check("R1 csr zero", cap_rdata, 32'd0);
    check("R1 host low", {31'b0, host_irq}, 32'd0);
  endtask

  task automatic t_csr_rw();
    access(0, 7'h38, 1, 32'hA5F0_0F5A);
    access(0, 7'h38, 0, 0);
    check("R2/R3 csr readback", cap_rdata, 32'hA570_0F5A);
    check("R6 host stays low", {31'b0, host_irq}, 32'd0);
  endtask

  task automatic t_raw_status();
    access(0, 7'h38, 1, 32'h0000_0000);
    ctl_irq = 1'b1;
    idle_cycle();
    access(0, 7'h38, 0, 0);
    check("R3 pending bit shows level", cap_rdata, 32'h0080_0000);
    check("R6 gated off while level high", {31'b0, host_irq}, 32'd0);
    ctl_irq = 1'b0;
    idle_cycle();
    access(0, 7'h38, 0, 0);
    check("R3 pending bit clears", cap_rdata, 32'h0000_0000);
  endtask

  task automatic t_gate();
    access(0, 7'h38, 1, 32'h0000_2000);
    check("R4 enabled no irq", {31'b0, host_irq}, 32'd0);
    ctl_irq = 1'b1;
    #1;
    check("R4 not before edge", {31'b0, host_irq}, 32'd0);
    idle_cycle();
    check("R4 host follows rise", {31'b0, host_irq}, 32'd1);
    ctl_irq = 1'b0;
    idle_cycle();
    check("R4 host follows fall", {31'b0, host_irq}, 32'd0);
  endtask

  task automatic t_toggle();
    access(0, 7'h38, 1, 32'h0000_0000);
    ctl_irq = 1'b1;
    idle_cycle();
    check("R6 pending disabled", {31'b0, host_irq}, 32'd0);
    access(0, 7'h38, 1, 32'h0000_2000);
    check("R5 enable with pending", {31'b0, host_irq}, 32'd1);
    access(0, 7'h38, 1, 32'h0000_0000);
    check("R5 disable with pending", {31'b0, host_irq}, 32'd0);
  endtask

  task automatic t_other_offsets();
    // irq still pending, enable clear
    access(0, 7'h38, 1, 32'h0000_1111);
    access(0, 7'h3C, 1, 32'hFFFF_FFFF);
    check("R7 host unaffected", {31'b0, host_irq}, 32'd0);
    access(0, 7'h00, 1, 32'h0000_2000);
    check("R7 host unaffected 0x00", {31'b0, host_irq}, 32'd0);
    access(0, 7'h38, 0, 0);
    check("R7 csr unchanged", cap_rdata, 32'h0080_1111);
    access(0, 7'h3C, 0, 0);
    check("R7 other offset reads zero", cap_rdata, 32'd0);
    access(0, 7'h34, 0, 0);
    check("R7 offset 0x34 reads zero", cap_rdata, 32'd0);
    ctl_irq = 1'b0;
    idle_cycle();
  endtask

  task automatic t_ctl_pass();
    access(1, 7'h05, 0, 0);
    check("R8 read strobe", {30'b0, cap_rd, cap_wr}, 32'd2);
    check("R8 read addr", {27'b0, cap_addr}, 32'd5);
    check("R8 read data", cap_rdata, 32'h0000_00A5);
    access(1, 7'h1F, 1, 32'hFFFF_FF3C);
    check("R8 write strobe", {30'b0, cap_rd, cap_wr}, 32'd1);
    check("R8 write addr", {27'b0, cap_addr}, 32'd31);
    check("R8 write byte", {24'b0, cap_wdata}, 32'h3C);
  endtask

  task automatic t_ctl_range();
    access(1, 7'h20, 0, 0);
    check("R9 no read strobe at 0x20", {30'b0, cap_rd, cap_wr}, 32'd0);
    check("R9 read zero at 0x20", cap_rdata, 32'd0);
    access(1, 7'h7F, 1, 32'h55);
    check("R9 no write strobe at 0x7F", {30'b0, cap_rd, cap_wr}, 32'd0);
  endtask

  task automatic t_aux();
    access(2, 7'h07, 0, 0);
    check("R10 version byte", cap_rdata, 32'h0000_00D0);
    access(2, 7'h00, 0, 0);
    check("R10 offset 0 zero", cap_rdata, 32'd0);
    access(2, 7'h03, 0, 0);
    check("R10 offset 3 zero", cap_rdata, 32'd0);
    access(2, 7'h0F, 0, 0);
    check("R10 beyond window zero", cap_rdata, 32'd0);
    access(2, 7'h07, 1, 32'hFFFF_FFFF);
    access(2, 7'h07, 0, 0);
    check("R10 write ignored", cap_rdata, 32'h0000_00D0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_csr_rw();
    t_raw_status();
    t_gate();
    t_toggle();
    t_other_offsets();
    t_ctl_pass();
    t_ctl_range();
    t_aux();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule